// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns the indexed-addressing postbyte of an 8-bit processor into a 16-bit effective address. Alongside the postbyte it takes up to two operand bytes that follow the postbyte, the four pointer registers, the two accumulators and the program counter value just past the operand bytes. It returns the effective address and a flag that asks the surrounding logic to fetch the final address through memory. It also reports how many operand bytes the form used. For the auto-update forms it returns a new pointer value, with an enable and the number of the register to write.

The generator is a single pipeline stage. A request presented with `in_valid` high is sampled at a rising clock edge, and every result is registered and visible after that edge with `out_valid` high. The memory read for the indirect case and any cycle accounting stay with the caller. The accumulator pair used as the 16-bit offset is `{acc_a, acc_b}`.

Top module: `idx_ea_gen`

## Requirements
- R1: Postbyte bits 6:5 pick the pointer register: 00 is `ptr_x`, 01 is `ptr_y`, 10 is `ptr_u`, 11 is `ptr_s`. For an auto-update form, `wb_sel` carries the same two-bit code.
- R2: With postbyte bit 7 clear, the address is the pointer plus bits 4:0 read as a signed 5-bit value. `extra_cnt` is 0, and `ind_req`, `wb_en` and `illegal` are 0.
- R3: With bit 7 set, a low nibble of 0000 or 0001 is post-increment. The address is the unchanged pointer, `wb_val` is the pointer plus 1 or plus 2 respectively, and `wb_en` is 1.
- R4: With bit 7 set, a low nibble of 0010 or 0011 is pre-decrement. The address and `wb_val` are both the pointer minus 1 or minus 2 respectively, and `wb_en` is 1.
- R5: With bit 7 set, these low nibbles add an offset to the pointer: 0100 adds nothing, 0101 adds `acc_b` sign-extended, 0110 adds `acc_a` sign-extended, and 1011 adds the 16-bit `{acc_a, acc_b}`, wrapping modulo 2^16.
- R6: With bit 7 set, low nibble 1000 adds `opnd_hi` sign-extended and gives `extra_cnt`=1. Low nibble 1001 adds `{opnd_hi, opnd_lo}`, with the first byte high, and gives `extra_cnt`=2.
- R7: With bit 7 set, low nibbles 1100 and 1101 work like 1000 and 1001, but the base is `pc_after` instead of the pointer.
- R8: With bit 7 set, bit 4 drives `ind_req` for every legal form. Low nibble 1111 with bit 4 set gives the address `{opnd_hi, opnd_lo}` with `extra_cnt`=2 and `ind_req`=1.
- R9: With bit 7 set, low nibbles 0111, 1010 and 1110, and 1111 with bit 4 clear, set `illegal`=1 and force `eff_addr`=0, `extra_cnt`=0, `ind_req`=0 and `wb_en`=0.
- R10: Results appear one clock after the request. A cycle with `in_valid` low yields `out_valid`, `wb_en`, `ind_req` and `illegal` all 0 on the next cycle.
- R11: While `rst` is high, every output is 0 after each clock edge, including when a request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| postbyte | input | 8 | Indexed-mode postbyte |
| opnd_hi | input | 8 | First byte after the postbyte |
| opnd_lo | input | 8 | Second byte after the postbyte |
| ptr_x | input | 16 | Pointer register, code 00 |
| ptr_y | input | 16 | Pointer register, code 01 |
| ptr_u | input | 16 | Pointer register, code 10 |
| ptr_s | input | 16 | Pointer register, code 11 |
| acc_a | input | 8 | Accumulator A, high half of the 16-bit pair |
| acc_b | input | 8 | Accumulator B, low half of the 16-bit pair |
| pc_after | input | 16 | Program counter past the operand bytes |
| out_valid | output | 1 | Registered results valid |
| eff_addr | output | 16 | Effective address, or the pointer location when indirect |
| ind_req | output | 1 | Final address must be read through memory |
| extra_cnt | output | 2 | Operand bytes consumed after the postbyte |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer to write back, same code as postbyte bits 6:5 |
| wb_val | output | 16 | New pointer value |
| illegal | output | 1 | Postbyte encodes no valid form |

## Verification
The bench targets the sign boundaries. These are a 5-bit offset of all ones, which must subtract 1, and accumulator and 8-bit offsets with the top bit set, which must subtract. A design that zero-extends any of them lands 256 or 32 bytes too high. It checks that post-increment hands out the old pointer and pre-decrement the new one, so swapped timing shows up as an address off by the step. It checks that `{acc_a, acc_b}` and the 16-bit offset are assembled high byte first and wrap past 0xFFFF, so a reversed byte order gives a visibly wrong address. It drives every reserved nibble, and 1111 without indirection, and expects every side effect to be suppressed. A decoder that treats them as a neighbouring form would raise a write-back or a byte count.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  typedef enum logic [3:0] {
    FORM_CONST5,
    FORM_INC1,
    FORM_INC2,
    FORM_DEC1,
    FORM_DEC2,
    FORM_ZERO,
    FORM_ACCB,
    FORM_ACCA,
    FORM_ACCD,
    FORM_OFF8,
    FORM_OFF16,
    FORM_PC8,
    FORM_PC16,
    FORM_EXTIND,
    FORM_BAD
  } idx_form_e;

  typedef enum logic [1:0] {
    BASE_PTR,
    BASE_PC,
    BASE_NONE
  } idx_base_e;

  typedef struct packed {
    idx_form_e  form;
    logic [1:0] ptr_code;
    logic       indirect;
    logic [1:0] extra;
  } idx_dec_t;

endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] postbyte,
  output idx_dec_t          dec
);

  localparam int MODE_BIT = DATA_W - 1;
  localparam int IND_BIT  = 4;

  logic       long_form;
  logic [3:0] nib;

  assign long_form = postbyte[MODE_BIT];
  assign nib       = postbyte[3:0];

  always_comb begin
    dec.ptr_code = postbyte[6:5];
    dec.indirect = 1'b0;
    dec.extra    = 2'd0;
    dec.form     = FORM_CONST5;
    if (long_form) begin
      dec.indirect = postbyte[IND_BIT];
      unique case (nib)
        4'b0000: dec.form = FORM_INC1;
        4'b0001: dec.form = FORM_INC2;
        4'b0010: dec.form = FORM_DEC1;
        4'b0011: dec.form = FORM_DEC2;
        4'b0100: dec.form = FORM_ZERO;
        4'b0101: dec.form = FORM_ACCB;
        4'b0110: dec.form = FORM_ACCA;
        4'b1011: dec.form = FORM_ACCD;
        4'b1000: begin dec.form = FORM_OFF8;  dec.extra = 2'd1; end
        4'b1001: begin dec.form = FORM_OFF16; dec.extra = 2'd2; end
        4'b1100: begin dec.form = FORM_PC8;   dec.extra = 2'd1; end
        4'b1101: begin dec.form = FORM_PC16;  dec.extra = 2'd2; end
        4'b1111: begin
          if (postbyte[IND_BIT]) begin
            dec.form  = FORM_EXTIND;
            dec.extra = 2'd2;
          end else begin
            dec.form = FORM_BAD;
          end
        end
        default: dec.form = FORM_BAD;
      endcase
      if (dec.form == FORM_BAD) begin
        dec.indirect = 1'b0;
        dec.extra    = 2'd0;
      end
    end
  end

endmodule

// File: rtl/idx_ea_offset.sv
module idx_ea_offset
  import idx_ea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  idx_form_e         form,
  input  logic [4:0]        short_off,
  input  logic [DATA_W-1:0] opnd_hi,
  input  logic [DATA_W-1:0] opnd_lo,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  output idx_base_e         base_sel,
  output logic [ADDR_W-1:0] ea_off,
  output logic [ADDR_W-1:0] wb_off,
  output logic              wb_hit
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] sx_short, sx_hi, sx_a, sx_b, pair_op, pair_acc;

  assign sx_short = ADDR_W'($signed(short_off));
  assign sx_hi    = ADDR_W'($signed(opnd_hi));
  assign sx_a     = ADDR_W'($signed(acc_a));
  assign sx_b     = ADDR_W'($signed(acc_b));
  assign pair_op  = ADDR_W'({opnd_hi, opnd_lo});
  assign pair_acc = ADDR_W'({acc_a, acc_b});

  always_comb begin
    base_sel = BASE_PTR;
    ea_off   = '0;
    wb_off   = '0;
    wb_hit   = 1'b0;
    unique case (form)
      FORM_CONST5: ea_off = sx_short;
      FORM_INC1:   begin wb_off = ONE; wb_hit = 1'b1; end
      FORM_INC2:   begin wb_off = TWO; wb_hit = 1'b1; end
      FORM_DEC1:   begin ea_off = -ONE; wb_off = -ONE; wb_hit = 1'b1; end
      FORM_DEC2:   begin ea_off = -TWO; wb_off = -TWO; wb_hit = 1'b1; end
      FORM_ZERO:   ea_off = '0;
      FORM_ACCB:   ea_off = sx_b;
      FORM_ACCA:   ea_off = sx_a;
      FORM_ACCD:   ea_off = pair_acc;
      FORM_OFF8:   ea_off = sx_hi;
      FORM_OFF16:  ea_off = pair_op;
      FORM_PC8:    begin base_sel = BASE_PC; ea_off = sx_hi; end
      FORM_PC16:   begin base_sel = BASE_PC; ea_off = pair_op; end
      FORM_EXTIND: begin base_sel = BASE_NONE; ea_off = pair_op; end
      default:     base_sel = BASE_NONE;
    endcase
  end

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] postbyte,
  input  logic [DATA_W-1:0] opnd_hi,
  input  logic [DATA_W-1:0] opnd_lo,
  input  logic [ADDR_W-1:0] ptr_x,
  input  logic [ADDR_W-1:0] ptr_y,
  input  logic [ADDR_W-1:0] ptr_u,
  input  logic [ADDR_W-1:0] ptr_s,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  input  logic [ADDR_W-1:0] pc_after,
  output logic              out_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              ind_req,
  output logic [1:0]        extra_cnt,
  output logic              wb_en,
  output logic [1:0]        wb_sel,
  output logic [ADDR_W-1:0] wb_val,
  output logic              illegal
);

  localparam int PTR_N = 4;

  idx_dec_t          dec;
  idx_base_e         base_sel;
  logic [ADDR_W-1:0] ea_off, wb_off, base, ptr_val, ea_nxt, wb_nxt;
  logic              wb_hit, bad;
  logic [ADDR_W-1:0] ptr_bank [PTR_N];

  assign ptr_bank[0] = ptr_x;
  assign ptr_bank[1] = ptr_y;
  assign ptr_bank[2] = ptr_u;
  assign ptr_bank[3] = ptr_s;

  idx_ea_decode #(.DATA_W(DATA_W)) u_decode (
    .postbyte (postbyte),
    .dec      (dec)
  );

  idx_ea_offset #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_offset (
    .form      (dec.form),
    .short_off (postbyte[4:0]),
    .opnd_hi   (opnd_hi),
    .opnd_lo   (opnd_lo),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .base_sel  (base_sel),
    .ea_off    (ea_off),
    .wb_off    (wb_off),
    .wb_hit    (wb_hit)
  );

  assign ptr_val = ptr_bank[dec.ptr_code];
  assign bad     = (dec.form == FORM_BAD);

  always_comb begin
    unique case (base_sel)
      BASE_PTR: base = ptr_val;
      BASE_PC:  base = pc_after;
      default:  base = '0;
    endcase
  end

  assign ea_nxt = bad ? '0 : (base + ea_off);
  assign wb_nxt = ptr_val + wb_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      eff_addr  <= '0;
      ind_req   <= 1'b0;
      extra_cnt <= 2'd0;
      wb_en     <= 1'b0;
      wb_sel    <= 2'd0;
      wb_val    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      eff_addr  <= in_valid ? ea_nxt : '0;
      ind_req   <= in_valid & dec.indirect;
      extra_cnt <= in_valid ? dec.extra : 2'd0;
      wb_en     <= in_valid & wb_hit;
      wb_sel    <= (in_valid & wb_hit) ? dec.ptr_code : 2'd0;
      wb_val    <= (in_valid & wb_hit) ? wb_nxt : '0;
      illegal   <= in_valid & bad;
    end
  end

endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] postbyte,
  input logic              out_valid,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              ind_req,
  input logic [1:0]        extra_cnt,
  input logic              wb_en,
  input logic [1:0]        wb_sel,
  input logic [ADDR_W-1:0] wb_val,
  input logic              illegal
);

  assert_wbsel_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && postbyte[7] && postbyte[3:1] == 3'b000)
      |=> (wb_sel == $past(postbyte[6:5])));

  assert_short_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !postbyte[7])
      |=> (extra_cnt == 2'd0 && !ind_req && !wb_en && !illegal));

  assert_postinc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && postbyte[7] && postbyte[3:1] == 3'b000)
      |=> (wb_en && (wb_val - eff_addr) ==
           ($past(postbyte[0]) ? ADDR_W'(2) : ADDR_W'(1))));

  assert_predec_same_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && postbyte[7] && postbyte[3:1] == 3'b001)
      |=> (wb_en && wb_val == eff_addr));

  assert_no_ind_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && postbyte[7] && !postbyte[4]) |=> !ind_req);

  assert_bad_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wb_en && !ind_req && extra_cnt == 2'd0 && eff_addr == '0));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wb_en && !ind_req && !illegal));

endmodule

bind idx_ea_gen idx_ea_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_idx_ea_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .postbyte  (postbyte),
  .out_valid (out_valid),
  .eff_addr  (eff_addr),
  .ind_req   (ind_req),
  .extra_cnt (extra_cnt),
  .wb_en     (wb_en),
  .wb_sel    (wb_sel),
  .wb_val    (wb_val),
  .illegal   (illegal)
);

// File: tb/test_idx_ea_gen.sv
`timescale 1ns/100ps
module test_idx_ea_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  postbyte = '0, opnd_hi = '0, opnd_lo = '0;
  logic [15:0] ptr_x = 16'h1000, ptr_y = 16'h2000, ptr_u = 16'h3000, ptr_s = 16'h4000;
  logic [7:0]  acc_a = 8'hF0, acc_b = 8'h05;
  logic [15:0] pc_after = 16'h8000;
  logic        out_valid, ind_req, wb_en, illegal;
  logic [15:0] eff_addr, wb_val;
  logic [1:0]  extra_cnt, wb_sel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idx_ea_gen i_idx_ea_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .postbyte(postbyte),
    .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .ptr_x(ptr_x), .ptr_y(ptr_y),
    .ptr_u(ptr_u), .ptr_s(ptr_s), .acc_a(acc_a), .acc_b(acc_b),
    .pc_after(pc_after), .out_valid(out_valid), .eff_addr(eff_addr),
    .ind_req(ind_req), .extra_cnt(extra_cnt), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_val(wb_val), .illegal(illegal)
  );

  typedef struct packed {
    logic [7:0]  pb;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] ea;
    logic        ind;
    logic [1:0]  nx;
    logic        wb;
    logic [1:0]  wsel;
    logic [15:0] wbv;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{8'h05, 8'h00, 8'h00, 16'h1005, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd2},  // R2 +5 on X
    '{8'h3F, 8'h00, 8'h00, 16'h1FFF, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd2},  // R2 -1 on Y
    '{8'h50, 8'h00, 8'h00, 16'h2FF0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd2},  // R2 -16 on U
    '{8'h60, 8'h00, 8'h00, 16'h4000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd1},  // R1 S
    '{8'h80, 8'h00, 8'h00, 16'h1000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h1001, 1'b0, 8'd3},  // R3 X+
    '{8'hA1, 8'h00, 8'h00, 16'h2000, 1'b0, 2'd0, 1'b1, 2'd1, 16'h2002, 1'b0, 8'd3},  // R3 Y++
    '{8'hC2, 8'h00, 8'h00, 16'h2FFF, 1'b0, 2'd0, 1'b1, 2'd2, 16'h2FFF, 1'b0, 8'd4},  // R4 -U
    '{8'hE3, 8'h00, 8'h00, 16'h3FFE, 1'b0, 2'd0, 1'b1, 2'd3, 16'h3FFE, 1'b0, 8'd4},  // R4 --S
    '{8'h84, 8'h00, 8'h00, 16'h1000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd5},  // R5 no offset
    '{8'h85, 8'h00, 8'h00, 16'h1005, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd5},  // R5 B
    '{8'h86, 8'h00, 8'h00, 16'h0FF0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd5},  // R5 A signed
    '{8'h8B, 8'h00, 8'h00, 16'h0005, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd5},  // R5 D wraps
    '{8'h88, 8'h80, 8'h00, 16'h0F80, 1'b0, 2'd1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd6},  // R6 8-bit -128
    '{8'hA9, 8'h12, 8'h34, 16'h3234, 1'b0, 2'd2, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd6},  // R6 16-bit
    '{8'h8C, 8'hFE, 8'h00, 16'h7FFE, 1'b0, 2'd1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd7},  // R7 PC-2
    '{8'h8D, 8'h01, 8'h00, 16'h8100, 1'b0, 2'd2, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd7},  // R7 PC+256
    '{8'h94, 8'h00, 8'h00, 16'h1000, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd8},  // R8 [,X]
    '{8'h9F, 8'hAB, 8'hCD, 16'hABCD, 1'b1, 2'd2, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd8},  // R8 extended ind
    '{8'hB1, 8'h00, 8'h00, 16'h2000, 1'b1, 2'd0, 1'b1, 2'd1, 16'h2002, 1'b0, 8'd8},  // R8 [,Y++]
    '{8'h8F, 8'h11, 8'h22, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b1, 8'd9},  // R9 1111 no ind
    '{8'h87, 8'h00, 8'h00, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b1, 8'd9},  // R9 0111
    '{8'h8A, 8'h00, 8'h00, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b1, 8'd9},  // R9 1010
    '{8'h9E, 8'h00, 8'h00, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b1, 8'd9},  // R9 1110 ind
    '{8'hF2, 8'h00, 8'h00, 16'h3FFF, 1'b1, 2'd0, 1'b1, 2'd3, 16'h3FFF, 1'b0, 8'd1}   // R1 [,-S]
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs zero during reset
    check(out_valid == 0 && eff_addr == 0 && wb_en == 0 && wb_val == 0 &&
          ind_req == 0 && extra_cnt == 0 && illegal == 0 && wb_sel == 0,
          "R11", "reset state", {16'h0, eff_addr}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      postbyte = VECS[i].pb;
      opnd_hi  = VECS[i].hi;
      opnd_lo  = VECS[i].lo;
      in_valid = 1'b1;
      @(negedge clk);
      check(out_valid && eff_addr == VECS[i].ea, $sformatf("R%0d", VECS[i].req),
            $sformatf("eff_addr pb=%h", VECS[i].pb), {16'h0, eff_addr}, {16'h0, VECS[i].ea});
      check(ind_req == VECS[i].ind && extra_cnt == VECS[i].nx && illegal == VECS[i].ill,
            $sformatf("R%0d", VECS[i].req), $sformatf("ind/extra/illegal pb=%h", VECS[i].pb),
            {28'h0, ind_req, extra_cnt, illegal}, {28'h0, VECS[i].ind, VECS[i].nx, VECS[i].ill});
      check(wb_en == VECS[i].wb && (!VECS[i].wb || (wb_val == VECS[i].wbv && wb_sel == VECS[i].wsel)),
            $sformatf("R%0d", VECS[i].req), $sformatf("write-back pb=%h", VECS[i].pb),
            {13'h0, wb_en, wb_sel, wb_val}, {13'h0, VECS[i].wb, VECS[i].wsel, VECS[i].wbv});
    end

    // R1: register select sweep with post-increment by one
    for (int r = 0; r < 4; r++) begin
      postbyte = 8'h80 | 8'(r << 5);
      @(negedge clk);
      check(wb_sel == 2'(r) && wb_val == 16'h1001 + 16'(r * 16'h1000) &&
            eff_addr == 16'h1000 + 16'(r * 16'h1000),
            "R1", "pointer select", {16'h0, eff_addr}, 32'h1000 + 32'(r * 32'h1000));
    end

    // R10: idle cycle after a request drops every flag
    in_valid = 1'b0;
    postbyte = 8'h80;
    @(negedge clk);
    check(!out_valid && !wb_en && !ind_req && !illegal, "R10", "idle",
          {28'h0, out_valid, wb_en, ind_req, illegal}, 32'h0);

    // R10: an illegal request followed by idle clears the flag
    postbyte = 8'h87;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(!illegal && !out_valid, "R10", "illegal cleared", {30'h0, illegal, out_valid}, 32'h0);

    // R11: reset overrides a present request
    postbyte = 8'h80;
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && !wb_en && eff_addr == 0 && wb_val == 0, "R11", "reset with request",
          {16'h0, wb_val}, 32'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule